// File: doc/BRIEF.md
# Doorbell Mailbox Console Endpoint

This block is the local end of a byte console that travels between a local processor and a remote host. The link uses four 32-bit registers that both sides can reach. Two are mailboxes: one carries bytes outward and one carries bytes inward. Two are doorbells: one rings the host and one is rung by the host. The block drives these registers through single-cycle write strobes. It sees their current contents on plain read ports, and the register file is expected to apply each write at the next clock edge.

Local software, or any local producer, hands bytes to the block on a valid/ready stream. Each byte is placed in the outgoing mailbox with its top bit set as a busy tag, and is announced with a DATA doorbell. When the host takes a byte, it clears that mailbox, which frees the slot. Bytes from the host arrive one at a time in the inward mailbox and are announced by a DATA doorbell. The block moves each one into a 256-entry ring and offers it on a second valid/ready stream. The host may only send again once the inward mailbox reads zero. The block therefore throttles the host by leaving that mailbox full whenever the ring is close to capacity.

Back-pressure works as follows. The outgoing stream stalls, with `tx_ready` low, while a byte is still held. This includes the carriage return that is added after each line feed. The incoming stream holds `rx_data` steady for as long as `rx_valid` is high and `rx_ready` is low.

Top module: `mbc_console`

## Requirements
- R1: After reset `connected` and `proto_err` are 0, `rx_valid` is 0, `tx_ready` is 1 and no register write strobe is active.
- R2: An incoming doorbell value of 0x1 (keep-alive) is answered with one outgoing doorbell write of 0x1.
- R3: Every incoming doorbell is acknowledged, whatever its code, with a single write of 0xFFFFFFFF to the incoming doorbell register. No acknowledge is issued without a pending doorbell.
- R4: An incoming doorbell of 0x2 (connect) empties the ring, drops the hold-off, clears the inward mailbox and sets `connected`.
- R5: An incoming doorbell of 0x5 (data) stores bits 7:0 of the inward mailbox at the ring tail. The mailbox is then cleared, provided the ring still has room.
- R6: When a stored byte brings the ring occupancy to 252 or more (fewer than 4 of the 255 usable entries free), the inward mailbox is left uncleared and the block holds off the host.
- R7: While holding off, a byte taken from the ring that brings occupancy below 252 ends the hold-off and clears the inward mailbox.
- R8: A byte is written to the outgoing mailbox only while that mailbox reads zero. It is written as 0x80000000 OR byte, together with an outgoing doorbell of 0x5. At most one byte is outstanding.
- R9: A byte of 0x0A sent on the local stream is followed on the link by a byte of 0x0D, without any further local input.
- R10: A pulse on `disc_req` produces an outgoing doorbell of 0x3 and clears `connected`.
- R11: An incoming doorbell code other than 0x1, 0x2 or 0x5 sets the sticky `proto_err` flag and has no other effect. The flag stays set until reset.
- R12: The ring hands bytes out in arrival order. Its pointers wrap modulo 256, and `rx_data` holds stable while a byte waits for `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 8 | Local byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Block accepts tx_data this cycle |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | Local reader takes rx_data |
| disc_req | input | 1 | Pulse: announce disconnect |
| connected | output | 1 | Host has connected |
| proto_err | output | 1 | Sticky: unknown doorbell code seen |
| tmb_rdata | input | 32 | Current outgoing mailbox contents |
| tmb_we | output | 1 | Write strobe for outgoing mailbox |
| tmb_wdata | output | 32 | Value for outgoing mailbox |
| rmb_rdata | input | 32 | Current inward mailbox contents |
| rmb_clr | output | 1 | Write zero to the inward mailbox |
| idb_pend | input | 1 | Incoming doorbell is pending |
| idb_rdata | input | 32 | Incoming doorbell code |
| idb_ack_we | output | 1 | Write strobe acknowledging the incoming doorbell |
| idb_ack_wdata | output | 32 | Acknowledge value (all ones) |
| odb_we | output | 1 | Write strobe for the outgoing doorbell |
| odb_wdata | output | 32 | Outgoing doorbell code |

## Verification
The assertions rely on the register file applying each strobe at the next edge. Under that assumption, an acknowledged doorbell stops pending, and a written outgoing mailbox reads non-zero, one cycle after the strobe. They also rely on the host announcing data only after the inward mailbox has read zero, and therefore never while the block is holding off. The bench's host model is a register file written at the edge that sees a strobe. Its tasks write the inward mailbox only after polling it back to zero, and ring a doorbell only after the previous one has been acknowledged.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  // Doorbell codes exchanged with the host
  localparam logic [WORD_W-1:0] DB_ALIVE = 32'h0000_0001;
  localparam logic [WORD_W-1:0] DB_CONN  = 32'h0000_0002;
  localparam logic [WORD_W-1:0] DB_DISC  = 32'h0000_0003;
  localparam logic [WORD_W-1:0] DB_DATA  = 32'h0000_0005;

  // Busy tag carried by every outgoing byte
  localparam logic [WORD_W-1:0] TX_TAG = 32'h8000_0000;

  localparam logic [BYTE_W-1:0] CH_LF = 8'h0A;
  localparam logic [BYTE_W-1:0] CH_CR = 8'h0D;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_DISC, ACT_ALIVE, ACT_CONN, ACT_DATA, ACT_BAD, ACT_SEND
  } act_t;

  typedef enum logic {ST_IDLE, ST_SETTLE} ctl_st_t;
endpackage

// File: rtl/mbc_tx_feed.sv
module mbc_tx_feed
  import mbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              sent,
  output logic              pend_valid,
  output logic [BYTE_W-1:0] pend_byte
);
  logic cr_owed;
  logic accept;

  assign in_ready = ~pend_valid;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_byte  <= '0;
      cr_owed    <= 1'b0;
    end else if (accept) begin
      pend_valid <= 1'b1;
      pend_byte  <= in_data;
      cr_owed    <= (in_data == CH_LF);
    end else if (sent) begin
      if (cr_owed) begin
        pend_byte <= CH_CR;
        cr_owed   <= 1'b0;
      end else begin
        pend_valid <= 1'b0;
      end
    end
  end

  AST_CR_AFTER_LF: assert property (@(posedge clk) disable iff (!rst_n)
    (sent && pend_byte == CH_LF) |=> (pend_valid && pend_byte == CH_CR)); // R9
endmodule

// File: rtl/mbc_rx_ring.sv
module mbc_rx_ring
  import mbc_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int HEADROOM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              mb_clear
);
  localparam int PW   = $clog2(DEPTH);
  localparam int MARK = DEPTH - HEADROOM;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp, rp, occ;
  logic [PW:0]       occ_next;
  logic              pop, held, held_n;

  assign occ      = wp - rp;
  assign rx_valid = (occ != '0);
  assign rx_data  = mem[rp];
  assign pop      = rx_valid & rx_ready & ~flush;
  assign occ_next = {1'b0, occ} + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};

  always_comb begin
    held_n   = held;
    mb_clear = 1'b0;
    if (!flush) begin
      if (push) begin
        if (occ_next >= (PW+1)'(MARK)) held_n = 1'b1;
        else                           mb_clear = 1'b1;
      end
      if (pop && held && occ_next < (PW+1)'(MARK)) begin
        held_n   = 1'b0;
        mb_clear = 1'b1;
      end
    end else begin
      held_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      held <= 1'b0;
    end else begin
      held <= held_n;
      if (flush) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (occ != PW'(DEPTH-1))); // R6
  AST_HELD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !pop && !flush) |-> !mb_clear); // R6
  AST_RX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !flush) |=> (rx_valid && $stable(rx_data))); // R12
endmodule

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disc_req,
  input  logic              idb_pend,
  input  logic [WORD_W-1:0] idb_rdata,
  input  logic [WORD_W-1:0] tmb_rdata,
  input  logic              pend_valid,
  input  logic [BYTE_W-1:0] pend_byte,
  input  logic              ring_mb_clear,
  output logic              ring_push,
  output logic              ring_flush,
  output logic              sent,
  output logic              tmb_we,
  output logic [WORD_W-1:0] tmb_wdata,
  output logic              rmb_clr,
  output logic              idb_ack_we,
  output logic              odb_we,
  output logic [WORD_W-1:0] odb_wdata,
  output logic              connected,
  output logic              proto_err
);
  ctl_st_t st;
  act_t    act;
  logic    disc_pend;

  always_comb begin
    act = ACT_NONE;
    if (st == ST_IDLE) begin
      if (disc_pend) begin
        act = ACT_DISC;
      end else if (idb_pend) begin
        case (idb_rdata)
          DB_ALIVE: act = ACT_ALIVE;
          DB_CONN:  act = ACT_CONN;
          DB_DATA:  act = ACT_DATA;
          default:  act = ACT_BAD;
        endcase
      end else if (pend_valid && tmb_rdata == '0) begin
        act = ACT_SEND;
      end
    end
  end

  assign ring_push  = (act == ACT_DATA);
  assign ring_flush = (act == ACT_CONN);
  assign sent       = (act == ACT_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      disc_pend  <= 1'b0;
      tmb_we     <= 1'b0;
      tmb_wdata  <= '0;
      rmb_clr    <= 1'b0;
      idb_ack_we <= 1'b0;
      odb_we     <= 1'b0;
      odb_wdata  <= '0;
      connected  <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      tmb_we     <= 1'b0;
      odb_we     <= 1'b0;
      idb_ack_we <= 1'b0;
      rmb_clr    <= ring_mb_clear | (act == ACT_CONN);
      st         <= (act != ACT_NONE) ? ST_SETTLE : ST_IDLE;
      if (disc_req) disc_pend <= 1'b1;
      case (act)
        ACT_DISC: begin
          odb_we    <= 1'b1;
          odb_wdata <= DB_DISC;
          connected <= 1'b0;
          disc_pend <= 1'b0;
        end
        ACT_ALIVE: begin
          odb_we     <= 1'b1;
          odb_wdata  <= DB_ALIVE;
          idb_ack_we <= 1'b1;
        end
        ACT_CONN: begin
          connected  <= 1'b1;
          idb_ack_we <= 1'b1;
        end
        ACT_DATA: idb_ack_we <= 1'b1;
        ACT_BAD: begin
          proto_err  <= 1'b1;
          idb_ack_we <= 1'b1;
        end
        ACT_SEND: begin
          tmb_we    <= 1'b1;
          tmb_wdata <= TX_TAG | {{(WORD_W-BYTE_W){1'b0}}, pend_byte};
          odb_we    <= 1'b1;
          odb_wdata <= DB_DATA;
        end
        default: ;
      endcase
    end
  end

  AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    idb_ack_we |-> $past(idb_pend)); // R3
  AST_TX_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    tmb_we |-> ($past(tmb_rdata) == '0)); // R8
  AST_TX_ANNOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
    tmb_we |-> (odb_we && odb_wdata == DB_DATA && tmb_wdata[WORD_W-1])); // R8
  AST_CONN_CLEARS_MB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(connected) |-> rmb_clr); // R4
  AST_DISC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (odb_we && odb_wdata == DB_DISC) |-> !connected); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err); // R11
endmodule

// File: rtl/mbc_console.sv
module mbc_console
  import mbc_pkg::*;
#(
  parameter int RING_DEPTH    = 256,
  parameter int RING_HEADROOM = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  input  logic        disc_req,
  output logic        connected,
  output logic        proto_err,
  input  logic [31:0] tmb_rdata,
  output logic        tmb_we,
  output logic [31:0] tmb_wdata,
  input  logic [31:0] rmb_rdata,
  output logic        rmb_clr,
  input  logic        idb_pend,
  input  logic [31:0] idb_rdata,
  output logic        idb_ack_we,
  output logic [31:0] idb_ack_wdata,
  output logic        odb_we,
  output logic [31:0] odb_wdata
);
  logic              pend_valid, sent;
  logic [BYTE_W-1:0] pend_byte;
  logic              ring_push, ring_flush, ring_mb_clear;
  logic              unused_rmb_hi;

  assign idb_ack_wdata = '1;
  assign unused_rmb_hi = ^rmb_rdata[WORD_W-1:BYTE_W];

  mbc_tx_feed u_feed (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_data    (tx_data),
    .in_valid   (tx_valid),
    .in_ready   (tx_ready),
    .sent       (sent),
    .pend_valid (pend_valid),
    .pend_byte  (pend_byte)
  );

  mbc_rx_ring #(
    .DEPTH    (RING_DEPTH),
    .HEADROOM (RING_HEADROOM)
  ) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (ring_flush),
    .push      (ring_push),
    .push_data (rmb_rdata[BYTE_W-1:0]),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .mb_clear  (ring_mb_clear)
  );

  mbc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .disc_req      (disc_req),
    .idb_pend      (idb_pend),
    .idb_rdata     (idb_rdata),
    .tmb_rdata     (tmb_rdata),
    .pend_valid    (pend_valid),
    .pend_byte     (pend_byte),
    .ring_mb_clear (ring_mb_clear),
    .ring_push     (ring_push),
    .ring_flush    (ring_flush),
    .sent          (sent),
    .tmb_we        (tmb_we),
    .tmb_wdata     (tmb_wdata),
    .rmb_clr       (rmb_clr),
    .idb_ack_we    (idb_ack_we),
    .odb_we        (odb_we),
    .odb_wdata     (odb_wdata),
    .connected     (connected),
    .proto_err     (proto_err)
  );
endmodule

// File: tb/test_mbc_console.sv
module test_mbc_console;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0, tx_ready;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_ready = 1'b0;
  logic        disc_req = 1'b0;
  logic        connected, proto_err;
  logic [31:0] tmb, rmb, idb;
  logic        tmb_we, rmb_clr, idb_ack_we, odb_we;
  logic [31:0] tmb_wdata, idb_ack_wdata, odb_wdata;

  // host-side stimulus pulses
  logic        h_tmb_take = 1'b0, h_rmb_wr = 1'b0, h_db_wr = 1'b0;
  logic [31:0] h_rmb_val = '0, h_db_val = '0;

  // host register file model and logs
  int          odb_n, tmb_n, ack_n;
  logic [31:0] odb_last;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mbc_console i_mbc_console (
    .clk(clk), .rst_n(rst_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .disc_req(disc_req), .connected(connected), .proto_err(proto_err),
    .tmb_rdata(tmb), .tmb_we(tmb_we), .tmb_wdata(tmb_wdata),
    .rmb_rdata(rmb), .rmb_clr(rmb_clr),
    .idb_pend(idb != '0), .idb_rdata(idb),
    .idb_ack_we(idb_ack_we), .idb_ack_wdata(idb_ack_wdata),
    .odb_we(odb_we), .odb_wdata(odb_wdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      tmb <= '0; rmb <= '0; idb <= '0;
      odb_n <= 0; tmb_n <= 0; ack_n <= 0; odb_last <= '0;
    end else begin
      if (tmb_we) begin tmb <= tmb_wdata; tmb_n <= tmb_n + 1; end
      else if (h_tmb_take) tmb <= '0;
      if (rmb_clr) rmb <= '0;
      else if (h_rmb_wr) rmb <= h_rmb_val;
      if (idb_ack_we) begin idb <= idb & ~idb_ack_wdata; ack_n <= ack_n + 1; end
      else if (h_db_wr) idb <= h_db_val;
      if (odb_we) begin odb_last <= odb_wdata; odb_n <= odb_n + 1; end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_ring(input logic [31:0] code);
    @(negedge clk); h_db_val = code; h_db_wr = 1'b1;
    @(negedge clk); h_db_wr = 1'b0;
    for (int i = 0; i < 20 && idb != '0; i++) @(negedge clk);
  endtask

  task automatic host_put(input logic [31:0] val);
    for (int i = 0; i < 50 && rmb != '0; i++) @(negedge clk);
    h_rmb_val = val; h_rmb_wr = 1'b1;
    @(negedge clk); h_rmb_wr = 1'b0;
    host_ring(32'h5);
  endtask

  task automatic host_take;
    @(negedge clk); h_tmb_take = 1'b1;
    @(negedge clk); h_tmb_take = 1'b0;
  endtask

  task automatic tx_send(input logic [7:0] b);
    @(negedge clk);
    for (int i = 0; i < 50 && !tx_ready; i++) @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 0; i < 50 && !rx_valid; i++) @(negedge clk);
    b = rx_data; rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "connected", connected, 0);
    check("R1", "proto_err", proto_err, 0);
    check("R1", "rx_valid", rx_valid, 0);
    check("R1", "tx_ready", tx_ready, 1);
    check("R1", "strobes", {tmb_we, rmb_clr, idb_ack_we, odb_we}, 0);
  endtask

  task automatic t_alive;
    int n0 = odb_n, a0 = ack_n;
    host_ring(32'h1); tick(2);
    check("R2", "doorbell count", odb_n, n0 + 1);
    check("R2", "doorbell code", odb_last, 32'h1);
    check("R3", "incoming cleared", idb, 0);
    check("R3", "one ack", ack_n, a0 + 1);
  endtask

  task automatic t_connect;
    @(negedge clk); h_rmb_val = 32'h55; h_rmb_wr = 1'b1;
    @(negedge clk); h_rmb_wr = 1'b0;
    host_ring(32'h2); tick(2);
    check("R4", "connected", connected, 1);
    check("R4", "inward mailbox cleared", rmb, 0);
    check("R4", "ring empty", rx_valid, 0);
  endtask

  task automatic t_data;
    logic [7:0] b;
    host_put(32'h8000_0141);
    host_put(32'h42);
    tick(3);
    check("R5", "mailbox cleared", rmb, 0);
    check("R12", "rx_valid", rx_valid, 1);
    b = rx_data; tick(3);
    check("R12", "stall holds data", rx_data, b);
    read_byte(b); check("R5", "first byte low bits", b, 8'h41);
    read_byte(b); check("R12", "second byte order", b, 8'h42);
    tick(1); check("R12", "ring drained", rx_valid, 0);
  endtask

  task automatic t_flow;
    logic [7:0] b;
    int bad = 0;
    for (int i = 0; i < 251; i++) host_put(32'(i));
    tick(3);
    check("R5", "mailbox cleared at 251", rmb, 0);
    host_put(32'd251); tick(4);
    check("R6", "mailbox held at 252", rmb, 32'd251);
    read_byte(b); tick(3);
    check("R7", "first byte out", b, 8'd0);
    check("R7", "mailbox released", rmb, 0);
    for (int i = 1; i < 252; i++) begin
      read_byte(b);
      if (b != 8'(i)) bad++;
    end
    check("R12", "drain order mismatches", bad, 0);
    for (int k = 0; k < 10; k++) host_put(32'(8'hA0 + k));
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      read_byte(b);
      if (b != 8'(8'hA0 + k)) bad++;
    end
    check("R12", "wrap order mismatches", bad, 0);
    tick(1); check("R12", "empty after wrap", rx_valid, 0);
  endtask

  task automatic t_tx;
    int t0 = tmb_n, n0 = odb_n;
    tx_send(8'h48); tick(4);
    check("R8", "tagged byte", tmb, 32'h8000_0048);
    check("R8", "data doorbell", odb_last, 32'h5);
    tx_send(8'h49); tick(6);
    check("R8", "busy slot untouched", tmb, 32'h8000_0048);
    check("R8", "one outstanding", tmb_n, t0 + 1);
    host_take; tick(4);
    check("R8", "second byte after free", tmb, 32'h8000_0049);
    check("R8", "doorbell per byte", odb_n, n0 + 2);
    host_take; tick(2);
  endtask

  task automatic t_lf;
    int t0 = tmb_n;
    tx_send(8'h0A); tick(4);
    check("R9", "line feed sent", tmb, 32'h8000_000A);
    host_take; tick(4);
    check("R9", "return follows", tmb, 32'h8000_000D);
    host_take; tick(4);
    check("R9", "nothing more", tmb_n, t0 + 2);
  endtask

  task automatic t_bad;
    int n0 = odb_n;
    host_ring(32'h7); tick(2);
    check("R3", "unknown acked", idb, 0);
    check("R11", "error raised", proto_err, 1);
    check("R11", "no doorbell out", odb_n, n0);
    check("R11", "still connected", connected, 1);
    check("R11", "ring untouched", rx_valid, 0);
    host_ring(32'h1); tick(2);
    check("R11", "error sticky", proto_err, 1);
  endtask

  task automatic t_flush;
    host_put(32'h11); host_put(32'h12); tick(3);
    check("R4", "ring filled", rx_valid, 1);
    host_ring(32'h2); tick(2);
    check("R4", "connect flushes", rx_valid, 0);
  endtask

  task automatic t_disc;
    @(negedge clk); disc_req = 1'b1;
    @(negedge clk); disc_req = 1'b0;
    tick(3);
    check("R10", "connected dropped", connected, 0);
    check("R10", "disconnect code", odb_last, 32'h3);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(1);
    t_reset; t_alive; t_connect; t_data; t_flow;
    t_tx; t_lf; t_bad; t_flush; t_disc;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end
endmodule